// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and a calendar in packed BCD registers: seconds, minutes, hours, day of month, month, day of week and a two-digit year. It is driven by a clock-enable strobe at the crystal rate, nominally 32.768 kHz. An internal prescaler divides that strobe down to one pulse per second. Each field counts within its own legal range and passes a carry to the next field. The length of each month, including the leap-year rule for February, is computed from the month and year registers.

Each register can be loaded through a single parallel port. A three-bit selector picks the register, and the loaded byte becomes visible on the next clock. All registers are driven continuously on parallel outputs. The hours register carries its own display format: a mode bit selects 12-hour or 24-hour counting, and in 12-hour mode a second bit marks the afternoon. The top bit of the seconds register is a halt flag that freezes the whole chain. Any load of seconds also clears the prescaler, so that a newly set time starts a full second later. Illegal BCD loads give undefined results.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the registers read seconds 0x00 (halt clear), minutes 0x00, hours 0x00 (24-hour mode), date 0x01, month 0x01, day of week 0x01, year 0x00.
- R2: When ld_en is high, ld_data is written into the register picked by ld_sel (0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year), and the new value is on the output after the next rising clk edge.
- R3: Seconds advance by one after every PRESCALE clock cycles in which tick_en is high. Cycles with tick_en low are not counted.
- R4: Seconds (bits 6:0) and minutes run from 00 to 59. When either wraps to 00 it advances the next field. In 24-hour mode (hours bit 7 = 0) hours run from 00 to 23, and the wrap from 23 to 00 marks midnight.
- R5: In 12-hour mode (hours bit 7 = 1), bits 4:0 hold 01 to 12 in the order 12, 01, ..., 11, and bit 5 is the PM flag (1 = PM). The flag toggles on the step from 11 to 12. Midnight is the step from 11 PM to 12 AM (0x92).
- R6: At midnight the date advances and wraps to 01 after its last day: 30 for months 04, 06, 09 and 11; 31 for the other months except February; 28 or 29 for February.
- R7: February has 29 days when the binary value of the year is divisible by 4, including year 00. Otherwise it has 28.
- R8: The month runs from 01 to 12. The wrap to 01 advances the year, which runs from 00 to 99 and wraps to 00.
- R9: The day of week advances at midnight through 1 to 7, and 7 is followed by 1.
- R10: While seconds bit 7 is 1, no register and no prescaler state changes except by a load. Bit 7 reads back as loaded. Loading seconds with bit 7 = 0 resumes counting.
- R11: Any load of the seconds register clears the prescaler, so the next increment needs a full PRESCALE counted ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timebase strobe, one cycle per crystal period |
| ld_en | input | 1 | Load strobe for the selected register |
| ld_sel | input | 3 | Register select for loads (0 seconds ... 6 year) |
| ld_data | input | 8 | Packed BCD value to load |
| sec_q | output | 8 | Seconds, bit 7 is the halt flag |
| min_q | output | 8 | Minutes |
| hour_q | output | 8 | Hours with mode and PM bits |
| date_q | output | 8 | Day of month |
| month_q | output | 8 | Month |
| wday_q | output | 8 | Day of week |
| year_q | output | 8 | Two-digit year |

## Verification
The assertions check on every cycle that the halt flag freezes all registers, that a seconds load lands on the next cycle, and that the carry chain is consistent. Minutes may only move on their own when seconds have just wrapped, the month when the date has returned to 01, and the day of week only when the time reads midnight. The bench has to show the values themselves. That covers month lengths and the leap rule, the year wrap, the 12-hour ordering and PM toggle, and the exact count of timebase ticks after a seconds load clears the prescaler. These are shown in directed rollover cases and in random load and tick sequences compared against a bench model that counts in binary.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef enum logic [2:0] {
      SEL_SEC   = 3'd0,
      SEL_MIN   = 3'd1,
      SEL_HOUR  = 3'd2,
      SEL_DATE  = 3'd3,
      SEL_MONTH = 3'd4,
      SEL_WDAY  = 3'd5,
      SEL_YEAR  = 3'd6
   } rtc_sel_e;

   // Packed BCD increment of a two-digit value (no range wrap)
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // Last day of the month in BCD, leap rule on the binary year value
   function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                 input logic [7:0] yr);
      logic [6:0] ybin;
      ybin = {3'b000, yr[7:4]} * 7'd10 + {3'b000, yr[3:0]};
      case (mon)
         8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int PRESCALE = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_en,
   input  logic run,
   input  logic clr,
   output logic sec_tick
);
   localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
   localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

   generate
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("rtc_prescaler: PRESCALE must be at least 2");
      end
   endgenerate

   logic [PW-1:0] cnt;

   assign sec_tick = tick_en && run && !clr && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clr)            cnt <= '0;
      else if (tick_en && run) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap
   import rtc_pkg::*;
#(
   parameter logic [7:0] LOW      = 8'h00,
   parameter logic [7:0] RST_VAL  = 8'h00,
   parameter bit         HOLD_MSB = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       ld,
   input  logic [7:0] ld_val,
   input  logic [7:0] hi,
   output logic [7:0] q,
   output logic       carry
);
   logic [7:0] field;
   logic [7:0] step;
   logic [7:0] nxt;
   logic       at_hi;

   generate
      if (HOLD_MSB) begin : g_hold_msb
         assign field = {1'b0, q[6:0]};
         assign nxt   = (step & 8'h7F) | {q[7], 7'b0};
      end else begin : g_full
         assign field = q;
         assign nxt   = step;
      end
   endgenerate

   assign at_hi = (field == hi);
   assign step  = at_hi ? LOW : bcd_inc(field);
   assign carry = inc && !ld && at_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RST_VAL;
      else if (ld)  q <= ld_val;
      else if (inc) q <= nxt;
   end
endmodule

// File: rtl/rtc_hour_ctr.sv
module rtc_hour_ctr
   import rtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       inc,
   input  logic       ld,
   input  logic [7:0] ld_val,
   output logic [7:0] q,
   output logic       carry
);
   logic [7:0] nxt;
   logic [7:0] t;
   logic       day_wrap;

   always_comb begin
      day_wrap = 1'b0;
      if (q[7]) begin
         t = bcd_inc({3'b000, q[4:0]});
         if (q[4:0] == 5'h12) begin
            nxt = {2'b10, q[5], 5'h01};
         end else if (q[4:0] == 5'h11) begin
            nxt      = {2'b10, ~q[5], 5'h12};
            day_wrap = q[5];
         end else begin
            nxt = 8'h80 | {2'b00, q[5], 5'b0} | (t & 8'h1F);
         end
      end else begin
         t = bcd_inc({2'b00, q[5:0]});
         if (q[5:0] == 6'h23) begin
            nxt      = 8'h00;
            day_wrap = 1'b1;
         end else begin
            nxt = t & 8'h3F;
         end
      end
   end

   assign carry = inc && !ld && day_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 8'h00;
      else if (ld)  q <= ld_val;
      else if (inc) q <= nxt;
   end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
   import rtc_pkg::*;
#(
   parameter int PRESCALE = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       ld_en,
   input  logic [2:0] ld_sel,
   input  logic [7:0] ld_data,
   output logic [7:0] sec_q,
   output logic [7:0] min_q,
   output logic [7:0] hour_q,
   output logic [7:0] date_q,
   output logic [7:0] month_q,
   output logic [7:0] wday_q,
   output logic [7:0] year_q
);
   logic ld_sec, ld_min, ld_hour, ld_date, ld_month, ld_wday, ld_year;
   logic sec_tick, c_sec, c_min, c_day, c_date, c_month;
   logic wday_wrap_unused, year_wrap_unused;

   assign ld_sec   = ld_en && (ld_sel == SEL_SEC);
   assign ld_min   = ld_en && (ld_sel == SEL_MIN);
   assign ld_hour  = ld_en && (ld_sel == SEL_HOUR);
   assign ld_date  = ld_en && (ld_sel == SEL_DATE);
   assign ld_month = ld_en && (ld_sel == SEL_MONTH);
   assign ld_wday  = ld_en && (ld_sel == SEL_WDAY);
   assign ld_year  = ld_en && (ld_sel == SEL_YEAR);

   rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .run(!sec_q[7]), .clr(ld_sec), .sec_tick(sec_tick));

   rtc_bcd_wrap #(.LOW(8'h00), .RST_VAL(8'h00), .HOLD_MSB(1'b1)) u_sec (
      .clk(clk), .rst_n(rst_n), .inc(sec_tick), .ld(ld_sec), .ld_val(ld_data),
      .hi(8'h59), .q(sec_q), .carry(c_sec));

   rtc_bcd_wrap #(.LOW(8'h00), .RST_VAL(8'h00), .HOLD_MSB(1'b0)) u_min (
      .clk(clk), .rst_n(rst_n), .inc(c_sec), .ld(ld_min), .ld_val(ld_data),
      .hi(8'h59), .q(min_q), .carry(c_min));

   rtc_hour_ctr u_hour (
      .clk(clk), .rst_n(rst_n), .inc(c_min), .ld(ld_hour), .ld_val(ld_data),
      .q(hour_q), .carry(c_day));

   rtc_bcd_wrap #(.LOW(8'h01), .RST_VAL(8'h01), .HOLD_MSB(1'b0)) u_date (
      .clk(clk), .rst_n(rst_n), .inc(c_day), .ld(ld_date), .ld_val(ld_data),
      .hi(month_last_day(month_q, year_q)), .q(date_q), .carry(c_date));

   rtc_bcd_wrap #(.LOW(8'h01), .RST_VAL(8'h01), .HOLD_MSB(1'b0)) u_wday (
      .clk(clk), .rst_n(rst_n), .inc(c_day), .ld(ld_wday), .ld_val(ld_data),
      .hi(8'h07), .q(wday_q), .carry(wday_wrap_unused));

   rtc_bcd_wrap #(.LOW(8'h01), .RST_VAL(8'h01), .HOLD_MSB(1'b0)) u_month (
      .clk(clk), .rst_n(rst_n), .inc(c_date), .ld(ld_month), .ld_val(ld_data),
      .hi(8'h12), .q(month_q), .carry(c_month));

   rtc_bcd_wrap #(.LOW(8'h00), .RST_VAL(8'h00), .HOLD_MSB(1'b0)) u_year (
      .clk(clk), .rst_n(rst_n), .inc(c_month), .ld(ld_year), .ld_val(ld_data),
      .hi(8'h99), .q(year_q), .carry(year_wrap_unused));
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ld_en,
   input logic [2:0] ld_sel,
   input logic [7:0] ld_data,
   input logic [7:0] sec_q,
   input logic [7:0] min_q,
   input logic [7:0] hour_q,
   input logic [7:0] date_q,
   input logic [7:0] month_q,
   input logic [7:0] wday_q,
   input logic [7:0] year_q
);
   // R10
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_q[7] && !ld_en) |=>
      ({sec_q, min_q, hour_q, date_q, month_q, wday_q, year_q} ==
       $past({sec_q, min_q, hour_q, date_q, month_q, wday_q, year_q})));

   // R2
   sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_en && ld_sel == 3'd0) |=> (sec_q == $past(ld_data)));

   // R4
   min_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((min_q != $past(min_q)) && !$past(ld_en)) |-> (sec_q[6:0] == 7'h00));

   // R8
   month_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((month_q != $past(month_q)) && !$past(ld_en)) |-> (date_q == 8'h01));

   // R9
   wday_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((wday_q != $past(wday_q)) && !$past(ld_en)) |->
      ((hour_q == 8'h00 || hour_q == 8'h92) && min_q == 8'h00 && sec_q[6:0] == 7'h00));
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (.*);

// File: tb/tb_rtc_bcd_calendar.sv
`timescale 1ns/1ps
module tb_rtc_bcd_calendar;
   localparam int P = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       ld_en = 1'b0;
   logic [2:0] ld_sel = 3'd0;
   logic [7:0] ld_data = 8'h00;
   logic [7:0] sec_q, min_q, hour_q, date_q, month_q, wday_q, year_q;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // bench model, binary
   int m_sec, m_min, m_hr, m_date, m_mon, m_wday, m_yr, m_pre;
   bit m_halt, m_12;

   always #4 clk = ~clk;

   rtc_bcd_calendar #(.PRESCALE(P)) dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ld_en(ld_en),
      .ld_sel(ld_sel), .ld_data(ld_data), .sec_q(sec_q), .min_q(min_q),
      .hour_q(hour_q), .date_q(date_q), .month_q(month_q), .wday_q(wday_q),
      .year_q(year_q));

   function automatic logic [7:0] to_bcd(input int v);
      return 8'((v / 10) * 16 + (v % 10));
   endfunction

   function automatic int from_bcd(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic int days_of(input int mon, input int yr);
      if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] exp_hour();
      int h;
      if (!m_12) return to_bcd(m_hr);
      h = m_hr % 12;
      if (h == 0) h = 12;
      return 8'h80 | ((m_hr >= 12) ? 8'h20 : 8'h00) | to_bcd(h);
   endfunction

   function automatic void advance();
      m_sec++;
      if (m_sec == 60) begin
         m_sec = 0; m_min++;
         if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin
               m_hr = 0;
               m_wday = (m_wday == 7) ? 1 : m_wday + 1;
               m_date++;
               if (m_date > days_of(m_mon, m_yr)) begin
                  m_date = 1; m_mon++;
                  if (m_mon > 12) begin
                     m_mon = 1;
                     m_yr = (m_yr + 1) % 100;
                  end
               end
            end
         end
      end
   endfunction

   task automatic chk(input string tag, input string nm, input logic [7:0] act,
                      input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s act=%h exp=%h", tag, nm, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "sec",   sec_q,   (m_halt ? 8'h80 : 8'h00) | to_bcd(m_sec));
      chk(tag, "min",   min_q,   to_bcd(m_min));
      chk(tag, "hour",  hour_q,  exp_hour());
      chk(tag, "date",  date_q,  to_bcd(m_date));
      chk(tag, "month", month_q, to_bcd(m_mon));
      chk(tag, "wday",  wday_q,  to_bcd(m_wday));
      chk(tag, "year",  year_q,  to_bcd(m_yr));
   endtask

   // one cycle with the given tick_en value; starts and ends just after negedge
   task automatic cyc(input bit en);
      tick_en = en;
      @(negedge clk);
      tick_en = 1'b0;
      if (en && !m_halt) begin
         m_pre++;
         if (m_pre == P) begin
            m_pre = 0;
            advance();
         end
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) cyc(1'b1);
   endtask

   task automatic load(input int sel, input logic [7:0] d);
      int h;
      ld_en = 1'b1; ld_sel = 3'(sel); ld_data = d;
      @(negedge clk);
      ld_en = 1'b0;
      case (sel)
         0: begin m_halt = d[7]; m_sec = from_bcd({1'b0, d[6:0]}); m_pre = 0; end
         1: m_min = from_bcd(d);
         2: begin
            m_12 = d[7];
            if (d[7]) begin
               h = from_bcd({3'b000, d[4:0]});
               m_hr = ((h == 12) ? 0 : h) + (d[5] ? 12 : 0);
            end else m_hr = from_bcd({2'b00, d[5:0]});
         end
         3: m_date = from_bcd(d);
         4: m_mon = from_bcd(d);
         5: m_wday = from_bcd(d);
         default: m_yr = from_bcd(d);
      endcase
   endtask

   task automatic set_all(input logic [7:0] yr, input logic [7:0] mon,
                          input logic [7:0] dt, input logic [7:0] hr,
                          input logic [7:0] mi, input logic [7:0] se);
      load(6, yr); load(4, mon); load(3, dt); load(2, hr); load(1, mi); load(0, se);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      summary();
   end

   initial begin
      void'($urandom(32'd1302));
      m_sec = 0; m_min = 0; m_hr = 0; m_date = 1; m_mon = 1; m_wday = 1;
      m_yr = 0; m_pre = 0; m_halt = 0; m_12 = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // R3: counted ticks versus idle cycles
      ticks(P - 1);
      check_all("R3");
      for (int i = 0; i < 5; i++) cyc(1'b0);
      check_all("R3");
      ticks(1);
      check_all("R3");

      // R2 loads, then R6/R9 February non-leap end, wday 7 -> 1
      set_all(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
      load(5, 8'h07);
      check_all("R2");
      ticks(P);
      check_all("R6_R9");

      // R7 leap years 24 and 00
      set_all(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
      ticks(P);
      check_all("R7");
      load(2, 8'h23); load(1, 8'h59); load(0, 8'h59);
      ticks(P);
      check_all("R7");
      set_all(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
      ticks(P);
      check_all("R7");

      // R6 thirty-day month and January end
      set_all(8'h31, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
      ticks(P);
      check_all("R6");
      set_all(8'h31, 8'h01, 8'h31, 8'h23, 8'h59, 8'h58);
      ticks(2 * P);
      check_all("R6");

      // R8 year end, year 99 -> 00; R4 carry chain
      set_all(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
      ticks(P);
      check_all("R8");

      // R5 12-hour mode
      set_all(8'h10, 8'h05, 8'h10, 8'h91, 8'h59, 8'h59);
      ticks(P);
      check_all("R5");
      load(2, 8'hB1); load(1, 8'h59); load(0, 8'h59);
      ticks(P);
      check_all("R5");
      load(1, 8'h59); load(0, 8'h59);
      ticks(P);
      check_all("R5");

      // R10 halt
      load(0, 8'h85);
      ticks(3 * P);
      check_all("R10");
      load(0, 8'h05);
      ticks(P);
      check_all("R10");

      // R11 prescaler cleared by seconds load
      ticks(P - 1);
      load(0, 8'h10);
      ticks(P - 1);
      check_all("R11");
      ticks(1);
      check_all("R11");

      // random mix
      load(3, 8'h01);
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom_range(0, 9));
         if (op < 3) begin
            int sel;
            sel = int'($urandom_range(0, 6));
            case (sel)
               0: load(0, (($urandom_range(0, 7) == 0) ? 8'h80 : 8'h00) |
                          to_bcd(int'($urandom_range(0, 1)) ? int'($urandom_range(55, 59))
                                                           : int'($urandom_range(0, 59))));
               1: load(1, to_bcd(int'($urandom_range(0, 1)) ? 59 : int'($urandom_range(0, 59))));
               2: if ($urandom_range(0, 1) == 1)
                     load(2, 8'h80 | (($urandom_range(0, 1) == 1) ? 8'h20 : 8'h00) |
                             to_bcd(int'($urandom_range(1, 12))));
                  else load(2, to_bcd(int'($urandom_range(0, 23))));
               3: load(3, to_bcd(int'($urandom_range(1, 28))));
               4: load(4, to_bcd(int'($urandom_range(1, 12))));
               5: load(5, to_bcd(int'($urandom_range(1, 7))));
               default: load(6, to_bcd(int'($urandom_range(0, 99))));
            endcase
            check_all("R2");
         end else begin
            int n;
            n = int'($urandom_range(1, 3 * P));
            for (int k = 0; k < n; k++) cyc(bit'($urandom_range(0, 3) != 0));
            check_all("R4");
         end
      end
      summary();
   end
endmodule